// File: doc/BRIEF.md
# Stand-Alone Conversion Start Controller

This block decides when a temperature converter runs. It takes two stored mode bits, a serial-select line, an asynchronous conversion-control pin, a host start command and a conversion-complete strobe. From these it issues single-cycle start requests to the converter and reports whether a conversion is in flight. When the host-mode bit is clear, the control pin can start work without any processor. A brief low pulse on the pin asks for one conversion. A low level held past a threshold asks for repeated conversions until the pin returns high. In this pin-driven use the stored single-shot bit has no say.

The block also keeps the high, low and combined thermostat outputs. These are loaded only from a completed conversion. Between conversions they keep their values, so an idle single-shot system still presents the result of its last valid reading. The control pin and the serial-select line are brought into the clock domain through a synchroniser chain before any edge or level decision is made. A saturating pulse-width timer measures how long the pin has been low.

Top module: `conv_start_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `start_o`, `busy_o`, `therm_hi_o`, `therm_lo_o` and `therm_any_o` are all 0.
- R2: With `single_mode_i`=1, a one-cycle `start_cmd_i` while idle gives exactly one `start_o` pulse. `busy_o` then stays 1 until the clock edge that samples `conv_done_i`=1, and the block returns to idle afterwards.
- R3: While `busy_o`=1, a start command or a falling edge on the control pin is dropped and not queued. No extra `start_o` follows once the conversion completes.
- R4: With `single_mode_i`=0, conversions run continuously. Each `start_o` after the first appears in the cycle directly after the complete strobe, and `busy_o` stays 1 throughout.
- R5: The pin path is enabled when `host_mode_i`=0 and `ser_sel_i`=0. In that state a falling edge on `ctl_pin_i` while idle starts exactly one conversion if the pin returns high before `LONG_CYC` synchronised cycles have passed. This holds even with `single_mode_i`=1.
- R6: With the pin path enabled, a pin held low for `LONG_CYC` synchronised cycles is treated as sustained. It starts a conversion if idle, and every complete strobe is then followed in the next cycle by another `start_o`.
- R7: When the pin goes high after a sustained low, the conversion in progress finishes, `busy_o` falls, and no further `start_o` is issued.
- R8: With `host_mode_i`=1, or with `ser_sel_i`=1, any activity on `ctl_pin_i` (short or long low) produces no `start_o`.
- R9: The thermostat outputs load `cmp_hi_i` and `cmp_lo_i` only on a clock edge where `busy_o`=1 and `conv_done_i`=1. The combined output is the OR of the two. A strobe while idle, and any comparator change between strobes, leaves all three outputs unchanged.
- R10: `start_o` is never high without `busy_o`, and `busy_o` never rises without `start_o` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_mode_i | input | 1 | Stored mode bit: 1 = pin used only as serial clock, 0 = pin may start conversions |
| single_mode_i | input | 1 | Stored mode bit: 1 = single conversion per command, 0 = continuous |
| ser_sel_i | input | 1 | Serial select line, asynchronous; high blocks the pin path |
| ctl_pin_i | input | 1 | Conversion-control pin, asynchronous, idles high |
| start_cmd_i | input | 1 | One-cycle host start-convert command |
| conv_done_i | input | 1 | One-cycle conversion-complete strobe from the converter |
| cmp_hi_i | input | 1 | Converter high-limit comparison, valid with the strobe |
| cmp_lo_i | input | 1 | Converter low-limit comparison, valid with the strobe |
| start_o | output | 1 | One-cycle start request to the converter |
| busy_o | output | 1 | Conversion in progress |
| therm_hi_o | output | 1 | Held high-limit thermostat output |
| therm_lo_o | output | 1 | Held low-limit thermostat output |
| therm_any_o | output | 1 | Held combined thermostat output |

## Verification
On every cycle, the properties check several points. The start pulse and the busy flag stay paired. Nothing restarts while a conversion runs without a strobe. A strobe in continuous mode, or under a sustained pin low, is followed at once by a new start. The pulse-width counter is cleared whenever the pin path is disabled. The thermostat outputs change only on a captured strobe and stay consistent with their OR. The rest can only be shown by the directed scenarios: how the pulse width splits one conversion from repeated ones, that a pin rise lets the current conversion finish and then stops, that the pin is blocked by either mode bit or the select line, and that start requests arriving while busy are lost.

// File: rtl/conv_ctrl_pkg.sv
package conv_ctrl_pkg;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_CONV = 1'b1
   } seq_state_e;

   typedef struct packed {
      logic hi;
      logic lo;
      logic any;
   } therm_t;

endpackage

// File: rtl/ccs_sync.sv
module ccs_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ccs_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/ccs_pulse_timer.sv
module ccs_pulse_timer #(
   parameter int LONG_CYC = 1_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic pin_s_i,
   output logic fall_o,
   output logic long_o
);

   localparam int CW = $clog2(LONG_CYC + 1);
   localparam logic [CW-1:0] LIMIT = CW'(LONG_CYC);

   if (LONG_CYC < 2) begin : g_bad_long
      $error("ccs_pulse_timer: LONG_CYC must be at least 2");
   end

   logic          pin_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b1;
      else        pin_q <= pin_s_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (!en_i || pin_s_i)  cnt_q <= '0;
      else if (cnt_q != LIMIT)    cnt_q <= cnt_q + 1'b1;
   end

   assign fall_o = en_i & pin_q & ~pin_s_i;
   assign long_o = en_i & ~pin_s_i & (cnt_q == LIMIT);

   p_cnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (cnt_q == '0))
      else $error("pulse timer kept counting with pin path disabled");

   p_cnt_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == LIMIT) && en_i && !pin_s_i |=> (cnt_q == LIMIT))
      else $error("pulse timer left saturation while pin held low");

endmodule

// File: rtl/ccs_sequencer.sv
module ccs_sequencer
   import conv_ctrl_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic single_mode_i,
   input  logic start_cmd_i,
   input  logic pin_fall_i,
   input  logic pin_long_i,
   input  logic conv_done_i,
   output logic start_o,
   output logic busy_o
);

   seq_state_e state_q, state_d;
   logic       start_q, start_d;
   logic       launch_c, again_c;

   always_comb begin
      launch_c = ~single_mode_i | start_cmd_i | pin_fall_i | pin_long_i;
      again_c  = ~single_mode_i | pin_long_i;
      state_d  = state_q;
      start_d  = 1'b0;
      unique case (state_q)
         SEQ_IDLE: begin
            if (launch_c) begin
               state_d = SEQ_CONV;
               start_d = 1'b1;
            end
         end
         SEQ_CONV: begin
            if (conv_done_i) begin
               if (again_c) start_d = 1'b1;
               else         state_d = SEQ_IDLE;
            end
         end
         default: state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         start_q <= 1'b0;
      end else begin
         state_q <= state_d;
         start_q <= start_d;
      end
   end

   assign start_o = start_q;
   assign busy_o  = (state_q == SEQ_CONV);

   p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> busy_o)
      else $error("start issued without busy");

   p_rose_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> start_o)
      else $error("busy rose without start");

   p_drop_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !conv_done_i |=> !start_o)
      else $error("restart during running conversion");

   p_cont_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && conv_done_i && !single_mode_i |=> start_o && busy_o)
      else $error("continuous mode missed back-to-back start");

   p_pin_repeat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && conv_done_i && pin_long_i |=> start_o)
      else $error("sustained pin low missed back-to-back start");

endmodule

// File: rtl/ccs_therm_hold.sv
module ccs_therm_hold
   import conv_ctrl_pkg::*;
#(
   parameter bit ANY_REG = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   capture_i,
   input  logic   hi_i,
   input  logic   lo_i,
   output therm_t therm_o
);

   logic hi_q, lo_q, any_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= 1'b0;
         lo_q <= 1'b0;
      end else if (capture_i) begin
         hi_q <= hi_i;
         lo_q <= lo_i;
      end
   end

   if (ANY_REG) begin : g_any_reg
      logic any_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         any_q <= 1'b0;
         else if (capture_i) any_q <= hi_i | lo_i;
      end
      assign any_w = any_q;
   end else begin : g_any_comb
      assign any_w = hi_q | lo_q;
   end

   assign therm_o = '{hi: hi_q, lo: lo_q, any: any_w};

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !capture_i |=> $stable(therm_o))
      else $error("thermostat outputs moved without a captured strobe");

   p_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      capture_i |=> (therm_o.hi == $past(hi_i)) && (therm_o.lo == $past(lo_i)))
      else $error("thermostat outputs did not load on strobe");

   p_any_or_r9: assert property (@(posedge clk) disable iff (!rst_n)
      therm_o.any == (therm_o.hi | therm_o.lo))
      else $error("combined thermostat output inconsistent");

endmodule

// File: rtl/conv_start_ctrl.sv
module conv_start_ctrl
   import conv_ctrl_pkg::*;
#(
   parameter int LONG_CYC    = 1_000_000,
   parameter int SYNC_STAGES = 2,
   parameter bit ANY_REG     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic host_mode_i,
   input  logic single_mode_i,
   input  logic ser_sel_i,
   input  logic ctl_pin_i,
   input  logic start_cmd_i,
   input  logic conv_done_i,
   input  logic cmp_hi_i,
   input  logic cmp_lo_i,
   output logic start_o,
   output logic busy_o,
   output logic therm_hi_o,
   output logic therm_lo_o,
   output logic therm_any_o
);

   logic   pin_s, sel_s, pin_en;
   logic   pin_fall, pin_long;
   therm_t therm;

   ccs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .d_i(ctl_pin_i), .q_o(pin_s)
   );

   ccs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sel_sync (
      .clk(clk), .rst_n(rst_n), .d_i(ser_sel_i), .q_o(sel_s)
   );

   assign pin_en = ~host_mode_i & ~sel_s;

   ccs_pulse_timer #(.LONG_CYC(LONG_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .en_i(pin_en), .pin_s_i(pin_s),
      .fall_o(pin_fall), .long_o(pin_long)
   );

   ccs_sequencer u_seq (
      .clk(clk), .rst_n(rst_n), .single_mode_i(single_mode_i),
      .start_cmd_i(start_cmd_i), .pin_fall_i(pin_fall), .pin_long_i(pin_long),
      .conv_done_i(conv_done_i), .start_o(start_o), .busy_o(busy_o)
   );

   ccs_therm_hold #(.ANY_REG(ANY_REG)) u_hold (
      .clk(clk), .rst_n(rst_n), .capture_i(busy_o & conv_done_i),
      .hi_i(cmp_hi_i), .lo_i(cmp_lo_i), .therm_o(therm)
   );

   assign therm_hi_o  = therm.hi;
   assign therm_lo_o  = therm.lo;
   assign therm_any_o = therm.any;

   p_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      host_mode_i && !busy_o && single_mode_i && !start_cmd_i |=> !start_o)
      else $error("pin started a conversion in host mode");

endmodule

// File: tb/tb_conv_start_ctrl.sv
`timescale 1ns/1ps
module tb_conv_start_ctrl;

   localparam int LONG = 16;
   localparam int LAT  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_mode_i = 1'b1, single_mode_i = 1'b1, ser_sel_i = 1'b0;
   logic ctl_pin_i = 1'b1, start_cmd_i = 1'b0, conv_done_i = 1'b0;
   logic cmp_hi_i = 1'b0, cmp_lo_i = 1'b0;
   logic start_o, busy_o, therm_hi_o, therm_lo_o, therm_any_o;

   int n_chk = 0, n_bad = 0;
   int n_start = 0, n_b2b = 0, n_pair_bad = 0;
   bit model_on = 1'b1;
   bit finished = 1'b0;
   int rem = 0;
   logic busy_prev = 1'b0;

   always #5 clk = ~clk;

   conv_start_ctrl #(.LONG_CYC(LONG), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .host_mode_i(host_mode_i),
      .single_mode_i(single_mode_i), .ser_sel_i(ser_sel_i),
      .ctl_pin_i(ctl_pin_i), .start_cmd_i(start_cmd_i),
      .conv_done_i(conv_done_i), .cmp_hi_i(cmp_hi_i), .cmp_lo_i(cmp_lo_i),
      .start_o(start_o), .busy_o(busy_o), .therm_hi_o(therm_hi_o),
      .therm_lo_o(therm_lo_o), .therm_any_o(therm_any_o)
   );

   // converter model and event counters, all at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (busy_o && !busy_prev && !start_o) n_pair_bad++;
            if (start_o && !busy_o) n_pair_bad++;
            if (start_o) begin
               n_start++;
               if (conv_done_i) n_b2b++;
               rem = LAT;
            end
         end
         busy_prev = busy_o;
         if (model_on) begin
            conv_done_i = 1'b0;
            if (!start_o && rem > 0) begin
               rem--;
               if (rem == 0) conv_done_i = 1'b1;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_cmd();
      @(negedge clk);
      start_cmd_i = 1'b1;
      @(negedge clk);
      start_cmd_i = 1'b0;
   endtask

   task automatic t_reset();
      cyc(3);
      chk({start_o, busy_o, therm_hi_o, therm_lo_o, therm_any_o} == 5'b0,
          "R1 during reset", {start_o, busy_o, therm_hi_o, therm_lo_o, therm_any_o}, 0);
      rst_n = 1'b1;
      cyc(3);
      chk({start_o, busy_o, therm_hi_o, therm_lo_o, therm_any_o} == 5'b0,
          "R1 after reset", {start_o, busy_o, therm_hi_o, therm_lo_o, therm_any_o}, 0);
   endtask

   task automatic t_host_oneshot();
      int s0 = n_start;
      pulse_cmd();
      chk(busy_o == 1'b1, "R2 busy after command", busy_o, 1);
      cyc(2);
      pulse_cmd();
      cyc(30);
      chk(n_start - s0 == 1, "R2 R3 one start per command", n_start - s0, 1);
      chk(busy_o == 1'b0, "R2 idle after strobe", busy_o, 0);
   endtask

   task automatic t_continuous();
      int s0 = n_start, b0 = n_b2b;
      single_mode_i = 1'b0;
      cyc(60);
      chk(n_start - s0 >= 5, "R4 continuous starts", n_start - s0, 5);
      chk(n_b2b - b0 >= 4, "R4 start right after strobe", n_b2b - b0, 4);
      chk(busy_o == 1'b1, "R4 busy held", busy_o, 1);
      single_mode_i = 1'b1;
      cyc(20);
      chk(busy_o == 1'b0, "R4 stop on single mode", busy_o, 0);
   endtask

   task automatic t_pin_short();
      int s0;
      host_mode_i = 1'b0;
      cyc(5);
      s0 = n_start;
      ctl_pin_i = 1'b0;
      cyc(5);
      ctl_pin_i = 1'b1;
      cyc(40);
      chk(n_start - s0 == 1, "R5 short low gives one conversion", n_start - s0, 1);
      chk(busy_o == 1'b0, "R5 idle after short low", busy_o, 0);
   endtask

   task automatic t_pin_busy_drop();
      int s0 = n_start;
      pulse_cmd();
      ctl_pin_i = 1'b0;
      cyc(2);
      ctl_pin_i = 1'b1;
      cyc(30);
      chk(n_start - s0 == 1, "R3 pin fall while busy dropped", n_start - s0, 1);
   endtask

   task automatic t_pin_long();
      int s0 = n_start, b0 = n_b2b, s1;
      ctl_pin_i = 1'b0;
      cyc(60);
      chk(n_start - s0 >= 3, "R6 sustained low repeats", n_start - s0, 3);
      chk(n_b2b - b0 >= 2, "R6 back-to-back starts", n_b2b - b0, 2);
      ctl_pin_i = 1'b1;
      cyc(3);
      s1 = n_start;
      cyc(30);
      chk(busy_o == 1'b0, "R7 idle after pin rise", busy_o, 0);
      chk(n_start == s1, "R7 no start after pin rise", n_start - s1, 0);
   endtask

   task automatic t_pin_blocked();
      int s0 = n_start;
      host_mode_i = 1'b1;
      ctl_pin_i = 1'b0;
      cyc(3);
      ctl_pin_i = 1'b1;
      cyc(5);
      ctl_pin_i = 1'b0;
      cyc(40);
      ctl_pin_i = 1'b1;
      cyc(10);
      chk(n_start == s0, "R8 host mode blocks pin", n_start - s0, 0);
      host_mode_i = 1'b0;
      ser_sel_i = 1'b1;
      cyc(5);
      ctl_pin_i = 1'b0;
      cyc(40);
      ctl_pin_i = 1'b1;
      cyc(5);
      ser_sel_i = 1'b0;
      cyc(10);
      chk(n_start == s0, "R8 serial select blocks pin", n_start - s0, 0);
      host_mode_i = 1'b1;
   endtask

   task automatic t_therm();
      cmp_hi_i = 1'b1; cmp_lo_i = 1'b0;
      pulse_cmd();
      cyc(20);
      chk({therm_hi_o, therm_lo_o, therm_any_o} == 3'b101, "R9 load high",
          {therm_hi_o, therm_lo_o, therm_any_o}, 5);
      cmp_hi_i = 1'b0; cmp_lo_i = 1'b1;
      cyc(10);
      chk({therm_hi_o, therm_lo_o, therm_any_o} == 3'b101, "R9 hold when idle",
          {therm_hi_o, therm_lo_o, therm_any_o}, 5);
      model_on = 1'b0;
      @(negedge clk); conv_done_i = 1'b1;
      @(negedge clk); conv_done_i = 1'b0;
      cyc(3);
      chk({therm_hi_o, therm_lo_o, therm_any_o} == 3'b101, "R9 idle strobe ignored",
          {therm_hi_o, therm_lo_o, therm_any_o}, 5);
      model_on = 1'b1;
      pulse_cmd();
      cyc(20);
      chk({therm_hi_o, therm_lo_o, therm_any_o} == 3'b011, "R9 load low",
          {therm_hi_o, therm_lo_o, therm_any_o}, 3);
      cmp_lo_i = 1'b0;
      pulse_cmd();
      cyc(20);
      chk({therm_hi_o, therm_lo_o, therm_any_o} == 3'b000, "R9 clear both",
          {therm_hi_o, therm_lo_o, therm_any_o}, 0);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
   end

   initial begin
      t_reset();
      t_host_oneshot();
      t_continuous();
      t_pin_short();
      t_pin_busy_drop();
      t_pin_long();
      t_pin_blocked();
      t_therm();
      chk(n_pair_bad == 0, "R10 start and busy paired", n_pair_bad, 0);
      summary();
   end

endmodule